// File: doc/BRIEF.md
# Dual Timer/Counter with Selectable Counting Modes

This block provides two independent 8+8-bit count channels for a microcontroller-style peripheral set. Each channel has a low byte and a high byte. It advances either on a machine-cycle strobe (timer operation) or on recognized falling edges of an external pin (counter operation). A gate pin can hold it stopped. A mode register picks one of four counting arrangements per channel. A control register holds a run bit and an overflow flag per channel, plus four spare bits that the block stores but does not use.

Software writes and reads all six registers through a small register port. The interrupt logic clears an overflow flag by pulsing the matching acknowledge line when it vectors to that channel's interrupt. The two overflow flags are also brought out as ports. The strobe input marks one machine cycle, which is twelve oscillator clocks in the intended system. The block itself only counts strobes.

Top module: `twin_timer`

## Requirements
- R1: After reset every register (control, mode, both low bytes, both high bytes) reads 0 and both overflow flags are 0.
- R2: Register addresses are 0 control, 1 mode, 2 channel-0 low, 3 channel-0 high, 4 channel-1 low, 5 channel-1 high. Reads are combinational. Addresses 6 and 7 read 0, and writes to them change nothing. Control bits from bit 7 down are flag1, run1, flag0, run0, then four stored spare bits. The mode register holds channel 1 in bits 7:4 and channel 0 in bits 3:0. In each nibble, from the top bit down, the bits are gate, source (1 = counter), and a 2-bit mode number.
- R3: In timer operation an enabled channel advances by one on each strobe. A channel is enabled only when its run bit is 1 and either its gate bit is 0 or its gate pin is 1.
- R4: In counter operation the pin is sampled on every strobe. The channel advances on the strobe that first samples 0 after a sample of 1. This gives at most one count every two strobes.
- R5: Mode 0 counts with a 13-bit value made from low[4:0] (least significant) and high[7:0]. Low[7:5] are never changed by counting. The flag sets when the 13-bit value wraps from all ones to 0.
- R6: Mode 1 counts with a 16-bit value {high, low}. The flag sets when it wraps from FFFFh to 0000h.
- R7: Mode 2 counts in the low byte only. On a count at FFh, the low byte is loaded from the high byte, the high byte is left unchanged, and the flag sets.
- R8: When channel 0 is in mode 3, its low byte is an 8-bit counter using channel 0's source, gate and run controls and setting flag0 on wrap. Its high byte counts every strobe while run1 is 1 and sets flag1 on wrap.
- R9: Channel 1 in mode 3 holds its count. While channel 0 is in mode 3, channel 1 counts in its own mode and with its own gate and source, ignoring run1, and its wraps set no flag.
- R10: A pulse on ackClr[n] clears flag n. A wrap that sets a flag in the same cycle as an acknowledge, or as a control write of 0 to that flag, leaves the flag at 1.
- R11: A register write to a count byte in the same cycle as a count leaves the written value in that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycTick | input | 1 | One-clock strobe marking each machine cycle |
| cntPin | input | 2 | External count inputs, bit n for channel n |
| gatePin | input | 2 | External gate inputs, bit n for channel n |
| ackClr | input | 2 | Flag-clear pulses from the interrupt logic |
| regWe | input | 1 | Register write enable |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data |
| ovfFlag | output | 2 | Overflow flags, bit n for channel n |

## Verification
A wrong count state shows on the read port on the very next strobe. A wrong carry or reload, however, only shows when a byte boundary is crossed. For that reason the sweeps start each channel a few counts below its wrap point and check the high byte and the flag as well as the low byte. A stale edge-detector sample shows as one extra or one missing count within two strobes of a pin change. A flag-priority error shows only in the cycle where an overflow and a clear collide, so those collisions are driven on purpose.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
  localparam int CNT_W  = 8;
  localparam int PRE_W  = 5;
  localparam int NCH    = 2;
  localparam int ADDR_W = 3;
  localparam int NCNT   = 2 * NCH;

  localparam logic [ADDR_W-1:0] ADR_CTL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CNT0 = 3'd2;

  // control register bit positions
  localparam int RUN_BASE  = 4;
  localparam int FLAG_BASE = 5;

  typedef struct packed {
    logic            stepLo0;
    logic            stepHi0;
    logic            stepCh1;
    logic [1:0]      mode0;
    logic [1:0]      mode1;
    logic [NCNT-1:0] wrCnt;   // lo0, hi0, lo1, hi1
  } tmrStrobe_t;

  typedef struct packed {
    logic             wrap;
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } advRes_t;

  function automatic advRes_t advance(input logic [CNT_W-1:0] lo,
                                      input logic [CNT_W-1:0] hi,
                                      input logic [1:0] mode);
    advRes_t r;
    logic [PRE_W:0] pre;
    logic [2*CNT_W:0] full;
    r.wrap = 1'b0;
    r.hi = hi;
    r.lo = lo;
    pre = '0;
    full = '0;
    case (mode)
      2'd0: begin
        pre = {1'b0, lo[PRE_W-1:0]} + 1'b1;
        r.lo[PRE_W-1:0] = pre[PRE_W-1:0];
        if (pre[PRE_W]) begin
          r.hi = hi + 1'b1;
          r.wrap = &hi;
        end
      end
      2'd1: begin
        full = {1'b0, hi, lo} + 1'b1;
        r.hi = full[2*CNT_W-1:CNT_W];
        r.lo = full[CNT_W-1:0];
        r.wrap = full[2*CNT_W];
      end
      2'd2: begin
        if (&lo) begin
          r.lo = hi;
          r.wrap = 1'b1;
        end else begin
          r.lo = lo + 1'b1;
        end
      end
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/twin_timer_ctrl.sv
module twin_timer_ctrl
  import twin_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycTick,
  input  logic [NCH-1:0]    cntPin,
  input  logic [NCH-1:0]    gatePin,
  input  logic [NCH-1:0]    ackClr,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              wrapLo0,
  input  logic              wrapHi0,
  input  logic              wrap1,
  output tmrStrobe_t        strb,
  output logic [CNT_W-1:0]  ctlQ,
  output logic [CNT_W-1:0]  modeQ
);
  logic [NCH-1:0] pinPrev;
  logic [NCH-1:0] chGo;
  logic [NCH-1:0] flagSet;
  logic [CNT_W-1:0] ctlN;
  logic split;
  logic wrCtl;
  logic wrMode;

  assign split  = (modeQ[1:0] == 2'd3);
  assign wrCtl  = regWe && (regAddr == ADR_CTL);
  assign wrMode = regWe && (regAddr == ADR_MODE);

  // per-channel gate and source qualification
  for (genvar ch = 0; ch < NCH; ch++) begin : g_qual
    logic gateOk;
    logic srcOk;
    assign gateOk = ~modeQ[4*ch+3] | gatePin[ch];
    assign srcOk  = modeQ[4*ch+2] ? (pinPrev[ch] & ~cntPin[ch]) : 1'b1;
    assign chGo[ch] = cycTick & gateOk & srcOk;
  end

  for (genvar w = 0; w < NCNT; w++) begin : g_wr
    assign strb.wrCnt[w] = regWe && (regAddr == ADR_CNT0 + ADDR_W'(w));
  end

  assign strb.mode0   = modeQ[1:0];
  assign strb.mode1   = modeQ[5:4];
  assign strb.stepLo0 = chGo[0] & ctlQ[RUN_BASE];
  assign strb.stepHi0 = cycTick & split & ctlQ[RUN_BASE+2];
  assign strb.stepCh1 = chGo[1] & (split | ctlQ[RUN_BASE+2]) & (modeQ[5:4] != 2'd3);

  assign flagSet[0] = wrapLo0;
  assign flagSet[1] = split ? wrapHi0 : wrap1;

  always_comb begin
    ctlN = wrCtl ? wrData : ctlQ;
    for (int ch = 0; ch < NCH; ch++) begin
      if (ackClr[ch] && !wrCtl) ctlN[FLAG_BASE+2*ch] = 1'b0;
      if (flagSet[ch])          ctlN[FLAG_BASE+2*ch] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ    <= '0;
      modeQ   <= '0;
      pinPrev <= '0;
    end else begin
      ctlQ <= ctlN;
      if (wrMode)  modeQ   <= wrData;
      if (cycTick) pinPrev <= cntPin;
    end
  end
endmodule

// File: rtl/twin_timer_dp.sv
module twin_timer_dp
  import twin_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] lo0Q,
  output logic [CNT_W-1:0] hi0Q,
  output logic [CNT_W-1:0] lo1Q,
  output logic [CNT_W-1:0] hi1Q,
  output logic             wrapLo0,
  output logic             wrapHi0,
  output logic             wrap1
);
  logic [CNT_W-1:0] cntQ [NCNT];
  logic [CNT_W-1:0] cntN [NCNT];
  logic [CNT_W-1:0] stepN [NCNT];
  advRes_t adv0;
  advRes_t adv1;

  assign lo0Q = cntQ[0];
  assign hi0Q = cntQ[1];
  assign lo1Q = cntQ[2];
  assign hi1Q = cntQ[3];

  always_comb begin
    adv0 = advance(cntQ[0], cntQ[1], strb.mode0);
    adv1 = advance(cntQ[2], cntQ[3], strb.mode1);
    for (int i = 0; i < NCNT; i++) stepN[i] = cntQ[i];
    wrapLo0 = 1'b0;
    wrapHi0 = 1'b0;
    wrap1   = 1'b0;
    if (strb.mode0 == 2'd3) begin
      if (strb.stepLo0) begin
        stepN[0] = cntQ[0] + 1'b1;
        wrapLo0  = &cntQ[0];
      end
      if (strb.stepHi0) begin
        stepN[1] = cntQ[1] + 1'b1;
        wrapHi0  = &cntQ[1];
      end
    end else if (strb.stepLo0) begin
      stepN[0] = adv0.lo;
      stepN[1] = adv0.hi;
      wrapLo0  = adv0.wrap;
    end
    if (strb.stepCh1) begin
      stepN[2] = adv1.lo;
      stepN[3] = adv1.hi;
      wrap1    = adv1.wrap;
    end
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    assign cntN[i] = strb.wrCnt[i] ? wrData : stepN[i];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cntQ[i] <= '0;
      else       cntQ[i] <= cntN[i];
    end
  end
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import twin_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycTick,
  input  logic [NCH-1:0]    cntPin,
  input  logic [NCH-1:0]    gatePin,
  input  logic [NCH-1:0]    ackClr,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  output logic [NCH-1:0]    ovfFlag
);
  tmrStrobe_t strb;
  logic [CNT_W-1:0] ctlQ, modeQ;
  logic [CNT_W-1:0] lo0Q, hi0Q, lo1Q, hi1Q;
  logic wrapLo0, wrapHi0, wrap1;

  twin_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cycTick(cycTick), .cntPin(cntPin),
    .gatePin(gatePin), .ackClr(ackClr), .regWe(regWe), .regAddr(regAddr),
    .wrData(regWdata), .wrapLo0(wrapLo0), .wrapHi0(wrapHi0), .wrap1(wrap1),
    .strb(strb), .ctlQ(ctlQ), .modeQ(modeQ)
  );

  twin_timer_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWdata),
    .lo0Q(lo0Q), .hi0Q(hi0Q), .lo1Q(lo1Q), .hi1Q(hi1Q),
    .wrapLo0(wrapLo0), .wrapHi0(wrapHi0), .wrap1(wrap1)
  );

  always_comb begin
    case (regAddr)
      3'd0:    regRdata = ctlQ;
      3'd1:    regRdata = modeQ;
      3'd2:    regRdata = lo0Q;
      3'd3:    regRdata = hi0Q;
      3'd4:    regRdata = lo1Q;
      3'd5:    regRdata = hi1Q;
      default: regRdata = '0;
    endcase
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_flag
    assign ovfFlag[ch] = ctlQ[FLAG_BASE+2*ch];
  end
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cycTick,
  input logic       regWe,
  input logic [2:0] regAddr,
  input logic       ack0,
  input logic       flag0,
  input logic [1:0] mode0Sel,
  input logic [1:0] mode1Sel,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1,
  input logic       wrapLo0
);
  // R3: without a strobe or a write no count byte moves
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cycTick && !regWe) |=> ($stable(lo0) && $stable(hi0) && $stable(lo1) && $stable(hi1)));

  // R5: mode 0 never touches the upper bits of the low byte
  a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    (mode0Sel == 2'd0 && !(regWe && regAddr == 3'd2)) |=> $stable(lo0[7:5]));

  // R7: a mode 2 wrap reloads the low byte from the high byte
  a_r7_reload: assert property (@(posedge clk) disable iff (!rstN)
    (wrapLo0 && mode0Sel == 2'd2 && !(regWe && (regAddr == 3'd2 || regAddr == 3'd3)))
      |=> (lo0 == $past(hi0)));

  // R9: channel 1 in mode 3 holds its bytes
  a_r9_ch1_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (mode1Sel == 2'd3 && !(regWe && (regAddr == 3'd4 || regAddr == 3'd5)))
      |=> ($stable(lo1) && $stable(hi1)));

  // R10: a wrap always leaves flag0 set
  a_r10_ovf_wins: assert property (@(posedge clk) disable iff (!rstN)
    wrapLo0 |=> flag0);

  // R10: an acknowledge with no wrap and no control write clears flag0
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ack0 && !wrapLo0 && !(regWe && regAddr == 3'd0)) |=> !flag0);
endmodule

bind twin_timer twin_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .cycTick(cycTick), .regWe(regWe), .regAddr(regAddr),
  .ack0(ackClr[0]), .flag0(ovfFlag[0]), .mode0Sel(modeQ[1:0]), .mode1Sel(modeQ[5:4]),
  .lo0(lo0Q), .hi0(hi0Q), .lo1(lo1Q), .hi1(hi1Q), .wrapLo0(wrapLo0)
);

// File: tb/sim_twin_timer.sv
`timescale 1ns/1ps
module sim_twin_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycTick = 1'b0;
  logic [1:0] cntPin = 2'b00;
  logic [1:0] gatePin = 2'b00;
  logic [1:0] ackClr = 2'b00;
  logic regWe = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic [1:0] ovfFlag;
  int total = 0;
  int bad = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  twin_timer u0 (
    .clk(clk), .rstN(rstN), .cycTick(cycTick), .cntPin(cntPin), .gatePin(gatePin),
    .ackClr(ackClr), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .ovfFlag(ovfFlag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cycTick = 1'b1;
      @(negedge clk); cycTick = 1'b0;
    end
  endtask

  task automatic tickPin(input logic p);
    @(negedge clk); cntPin[0] = p; cycTick = 1'b1;
    @(negedge clk); cycTick = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), rv); chk("R1 reg after reset", rv, 0);
    end
    chk("R1 flags after reset", ovfFlag, 0);

    // R2 map, spare bits, unused addresses
    wr(3'd6, 8'h55); rd(3'd6, rv); chk("R2 unused addr reads 0", rv, 0);
    rd(3'd7, rv); chk("R2 addr 7 reads 0", rv, 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), rv); chk("R2 unused write no effect", rv, 0);
    end
    wr(3'd0, 8'h0F); rd(3'd0, rv); chk("R2 spare ctl bits", rv, 8'h0F);
    wr(3'd1, 8'hA4); rd(3'd1, rv); chk("R2 mode readback", rv, 8'hA4);

    // R3 timer counting and gating, channel 0 mode 1
    wr(3'd1, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h10);
    tick(5); rd(3'd2, rv); chk("R3 one count per strobe", rv, 5);
    wr(3'd1, 8'h09); gatePin[0] = 1'b0;
    tick(3); rd(3'd2, rv); chk("R3 gate pin low holds", rv, 5);
    gatePin[0] = 1'b1;
    tick(3); rd(3'd2, rv); chk("R3 gate pin high counts", rv, 8);
    wr(3'd0, 8'h00);
    tick(4); rd(3'd2, rv); chk("R3 run bit off holds", rv, 8);

    // R4 counter operation on pattern and on toggling
    begin
      logic [15:0] pat;
      logic prevP;
      int expC;
      pat = 16'hB2E6; prevP = 1'b0; expC = 0;
      wr(3'd1, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h10);
      for (int i = 0; i < 16; i++) begin
        tickPin(pat[i]);
        if (prevP && !pat[i]) expC++;
        prevP = pat[i];
      end
      rd(3'd2, rv); chk("R4 falling samples counted", rv, expC);
      for (int i = 0; i < 10; i++) tickPin(i[0] ? 1'b0 : 1'b1);
      rd(3'd2, rv); chk("R4 toggling gives half rate", rv, expC + 5);
      for (int i = 0; i < 6; i++) tickPin(1'b1);
      rd(3'd2, rv); chk("R4 steady high no count", rv, expC + 5);
      cntPin[0] = 1'b0;
      tick(1);
    end

    // R5 mode 0 sweep over prescaler start values
    wr(3'd1, 8'h00);
    for (int s = 0; s < 32; s++) begin
      int st, en, n;
      n = 20 + s;
      st = 8160 + s;
      en = st + n;
      wr(3'd0, 8'h10); wr(3'd3, 8'hFF); wr(3'd2, {3'b101, 5'(s)});
      tick(n);
      rd(3'd2, rv); chk("R5 low byte", rv, {3'b101, 5'(en % 8192)});
      rd(3'd3, rv); chk("R5 high byte", rv, (en % 8192) >> 5);
      chk("R5 flag on 13-bit wrap", ovfFlag[0], (en >= 8192) ? 1 : 0);
    end

    // R6 mode 1 sweep on channel 1
    wr(3'd1, 8'h10);
    for (int k = 0; k < 16; k++) begin
      int en;
      en = 16'hFFF0 + k + 12;
      wr(3'd0, 8'h40); wr(3'd5, 8'hFF); wr(3'd4, 8'(8'hF0 + k));
      tick(12);
      rd(3'd4, rv); chk("R6 low byte", rv, en & 255);
      rd(3'd5, rv); chk("R6 high byte", rv, (en >> 8) & 255);
      chk("R6 flag on 16-bit wrap", ovfFlag[1], (en >= 65536) ? 1 : 0);
    end

    // R7 mode 2 reload sweep on channel 0
    wr(3'd1, 8'h02);
    for (int r = 0; r < 8; r++) begin
      int v, h;
      bit f;
      h = 8'hF8 + r; v = 8'hFC; f = 1'b0;
      wr(3'd0, 8'h10); wr(3'd3, 8'(h)); wr(3'd2, 8'hFC);
      tick(10);
      for (int t = 0; t < 10; t++) begin
        if (v == 255) begin v = h; f = 1'b1; end
        else v = v + 1;
      end
      rd(3'd2, rv); chk("R7 low byte reload", rv, v);
      rd(3'd3, rv); chk("R7 high byte unchanged", rv, h);
      chk("R7 flag", ovfFlag[0], f);
    end

    // R8 split mode on channel 0
    wr(3'd1, 8'h03); wr(3'd2, 8'hF0); wr(3'd3, 8'hF8); wr(3'd0, 8'h50);
    tick(16);
    rd(3'd2, rv); chk("R8 low counter wraps", rv, 8'h00);
    rd(3'd3, rv); chk("R8 high counter wraps", rv, 8'h08);
    rd(3'd0, rv); chk("R8 both flags set", rv, 8'hF0);
    chk("R8 flag ports", ovfFlag, 2'b11);
    wr(3'd1, 8'h0B); wr(3'd0, 8'h50); wr(3'd2, 8'h10); wr(3'd3, 8'h20);
    gatePin[0] = 1'b0;
    tick(4);
    rd(3'd2, rv); chk("R8 gate stops low counter", rv, 8'h10);
    rd(3'd3, rv); chk("R8 high counter ignores gate", rv, 8'h24);
    gatePin[0] = 1'b1;

    // R9 channel 1 during split and in its own mode 3
    wr(3'd1, 8'h13); wr(3'd0, 8'h00); wr(3'd4, 8'hFE); wr(3'd5, 8'hFF); wr(3'd3, 8'h33);
    tick(3);
    rd(3'd4, rv); chk("R9 ch1 runs without run1", rv, 8'h01);
    rd(3'd5, rv); chk("R9 ch1 high wraps", rv, 8'h00);
    chk("R9 ch1 wrap sets no flag", ovfFlag, 2'b00);
    rd(3'd3, rv); chk("R9 ch0 high idle with run1 off", rv, 8'h33);
    wr(3'd1, 8'h31); wr(3'd0, 8'h40); wr(3'd4, 8'h05); wr(3'd5, 8'h07);
    tick(5);
    rd(3'd4, rv); chk("R9 ch1 mode 3 low frozen", rv, 8'h05);
    rd(3'd5, rv); chk("R9 ch1 mode 3 high frozen", rv, 8'h07);

    // R10 acknowledge and overflow priority
    wr(3'd0, 8'h20);
    chk("R10 flag set by write", ovfFlag[0], 1);
    @(negedge clk); ackClr[0] = 1'b1;
    @(negedge clk); ackClr[0] = 1'b0;
    chk("R10 ack clears flag", ovfFlag[0], 0);
    wr(3'd1, 8'h01); wr(3'd0, 8'h10); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    @(negedge clk); cycTick = 1'b1; ackClr[0] = 1'b1;
    @(negedge clk); cycTick = 1'b0; ackClr[0] = 1'b0;
    chk("R10 overflow beats ack", ovfFlag[0], 1);
    wr(3'd0, 8'h10); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    @(negedge clk); cycTick = 1'b1; regWe = 1'b1; regAddr = 3'd0; regWdata = 8'h10;
    @(negedge clk); cycTick = 1'b0; regWe = 1'b0;
    rd(3'd0, rv); chk("R10 overflow beats control write", rv, 8'h30);

    // R11 write beats count
    wr(3'd2, 8'h10); wr(3'd3, 8'h44);
    @(negedge clk); cycTick = 1'b1; regWe = 1'b1; regAddr = 3'd2; regWdata = 8'h77;
    @(negedge clk); cycTick = 1'b0; regWe = 1'b0;
    rd(3'd2, rv); chk("R11 written value kept", rv, 8'h77);
    rd(3'd3, rv); chk("R11 high byte untouched", rv, 8'h44);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule